// File: doc/BRIEF.md
# Triangular Down-Spread Ratio Generator

This block drives the feedback divider of a fractional-N PLL so that a nominal 100 MHz clock, synthesized from a 27 MHz reference, is spread downward in frequency along a triangular profile. It runs on the reference clock. Every cycle it presents an unsigned fixed-point feedback ratio with 4 integer bits and 20 fractional bits. The nominal value 100/27 is the top of the sweep. A sweep offset is subtracted from it, and that offset rises linearly and then falls linearly.

Two select inputs choose the depth. Each select has already been resolved to a three-level code. Together they give nine settings: one setting turns spreading off and eight give depths between 0.25 % and 3 %.

A new selection is captured at once. It takes effect only when the sweep is back at its top, where the offset is zero, so the ratio never jumps. An output flag shows whether the applied setting is spreading.

Top module: `ssc_ratio_gen`

## Requirements
- R1: After reset the ratio equals NOM = round(100·2^20/27) = 3883615 and `spread_on` is 0.
- R2: Level codes are 2'b00 low, 2'b01 mid, 2'b10 high, and 2'b11 is decoded as low. The depth in units of 0.25 % is given by (outer select, inner select): low/low 0 (off), low/mid 2, low/high 10, mid/low 1, mid/mid 3, mid/high 4, high/low 6, high/mid 8, high/high 12.
- R3: While the applied depth is 0, the ratio stays at NOM and `spread_on` is 0.
- R4: With a nonzero depth the sweep period is 844 reference cycles. The ratio is back at NOM every 844 cycles.
- R5: Over one period the ratio falls by exactly step = floor(NOM·q/(400·422)) per cycle for 422 cycles, then rises by step per cycle for 422 cycles.
- R6: The ratio never exceeds NOM. Its minimum within a period is NOM − 422·step.
- R7: A select change is applied only at the sweep top. The current period finishes with the old step. From the off state, the flag rises on the second clock edge after the change. In all cases the new setting applies within 846 cycles.
- R8: `spread_on` is 1 exactly while the applied depth is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_outer | input | 2 | Outer depth select, three-level code |
| sel_inner | input | 2 | Inner depth select, three-level code |
| ratio | output | 24 | Feedback ratio, 4.20 unsigned fixed point |
| spread_on | output | 1 | Applied setting is spreading |

## Verification
The hardest situation to reach from the ports is a depth change in the middle of a ramp. In that case the old step must carry on to the top, and only then may the new one take over. The bench changes the selects at a fixed cycle inside the down ramp of a 3 % sweep. It then checks every remaining cycle of that period against the 3 % step, and every cycle of the following period against the 0.25 % step. The reserved level code is driven on each select to show that it reads as low.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    LVL_LO  = 2'b00,
    LVL_MID = 2'b01,
    LVL_HI  = 2'b10,
    LVL_RSV = 2'b11
  } lvl_e;

  // depth is counted in quarter-percent units
  function automatic longint calc_step(input longint nom, input int quarters, input int half);
    return (nom * longint'(quarters)) / (longint'(400) * longint'(half));
  endfunction
endpackage

// File: rtl/ssc_rst_sync.sv
module ssc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= 2'b00;
    else        shreg_q <= {shreg_q[0], 1'b1};
  end

  assign rst_n_sync = shreg_q[1];
endmodule

// File: rtl/ssc_dev_decode.sv
module ssc_dev_decode
  import ssc_pkg::*;
(
  input  logic [1:0] sel_outer,
  input  logic [1:0] sel_inner,
  output logic [3:0] quarters
);
  lvl_e outer_l, inner_l;

  // the reserved code reads as low, like an open pin
  always_comb begin
    outer_l = (lvl_e'(sel_outer) == LVL_RSV) ? LVL_LO : lvl_e'(sel_outer);
    inner_l = (lvl_e'(sel_inner) == LVL_RSV) ? LVL_LO : lvl_e'(sel_inner);
  end

  always_comb begin
    quarters = 4'd0;
    unique case (outer_l)
      LVL_LO: begin
        unique case (inner_l)
          LVL_MID: quarters = 4'd2;
          LVL_HI:  quarters = 4'd10;
          default: quarters = 4'd0;
        endcase
      end
      LVL_MID: begin
        unique case (inner_l)
          LVL_MID: quarters = 4'd3;
          LVL_HI:  quarters = 4'd4;
          default: quarters = 4'd1;
        endcase
      end
      default: begin
        unique case (inner_l)
          LVL_MID: quarters = 4'd8;
          LVL_HI:  quarters = 4'd12;
          default: quarters = 4'd6;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ssc_step_rom.sv
module ssc_step_rom
  import ssc_pkg::*;
#(
  parameter int     RATIO_W  = 24,
  parameter longint NOM      = 3883615,
  parameter int     HALF_CYC = 422
) (
  input  logic [3:0]         quarters,
  output logic [RATIO_W-1:0] step
);
  localparam int ENTRIES = 16;

  logic [RATIO_W-1:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign tbl[i] = RATIO_W'(calc_step(NOM, i, HALF_CYC));
  end

  assign step = tbl[quarters];
endmodule

// File: rtl/ssc_sweep_core.sv
module ssc_sweep_core #(
  parameter int RATIO_W  = 24,
  parameter int HALF_CYC = 422
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         pend_q,
  input  logic [RATIO_W-1:0] step_pend,
  input  logic [RATIO_W-1:0] step_cur,
  output logic [3:0]         cur_q,
  output logic [RATIO_W-1:0] off_q
);
  localparam int PERIOD = 2 * HALF_CYC;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RATIO_W-1:0] off_d;
  logic [3:0]         cur_d;
  logic               at_top, adv_en;

  assign at_top = (cnt_q == '0);
  // the state moves when a sweep is running or one is about to start
  assign adv_en = !at_top || (pend_q != 4'd0) || (cur_q != 4'd0);

  always_comb begin
    cnt_d = cnt_q;
    off_d = off_q;
    cur_d = cur_q;
    if (at_top) begin
      cur_d = pend_q;
      if (pend_q != 4'd0) begin
        cnt_d = CNT_W'(1);
        off_d = step_pend;
      end
    end else begin
      if (cnt_q < CNT_HALF) off_d = off_q + step_cur;
      else                  off_d = off_q - step_cur;
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= '0;
      cur_q <= 4'd0;
    end else if (adv_en) begin
      cnt_q <= cnt_d;
      off_q <= off_d;
      cur_q <= cur_d;
    end
  end

  AST_TOP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |-> (off_q == '0)); // R4

  AST_SWITCH_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> ($past(cnt_q) == '0)); // R7

  AST_IDLE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == 4'd0) |-> (off_q == '0)); // R3

  AST_FULL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_HALF) |-> (off_q == RATIO_W'(HALF_CYC * step_cur))); // R6
endmodule

// File: rtl/ssc_ratio_gen.sv
module ssc_ratio_gen #(
  parameter int INT_W    = 4,
  parameter int FRAC_W   = 20,
  parameter int REF_MHZ  = 27,
  parameter int OUT_MHZ  = 100,
  parameter int HALF_CYC = 422
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                sel_outer,
  input  logic [1:0]                sel_inner,
  output logic [INT_W+FRAC_W-1:0]   ratio,
  output logic                      spread_on
);
  localparam int     RATIO_W = INT_W + FRAC_W;
  localparam longint NOM_L   = ((longint'(OUT_MHZ) << (FRAC_W + 1)) + longint'(REF_MHZ))
                               / (longint'(2) * longint'(REF_MHZ));
  localparam logic [RATIO_W-1:0] NOM = RATIO_W'(NOM_L);

  logic               rst_n_s;
  logic [3:0]         dec_q, pend_q, cur_q;
  logic [RATIO_W-1:0] step_pend, step_cur, off_q;

  ssc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ssc_dev_decode u_dec (
    .sel_outer (sel_outer),
    .sel_inner (sel_inner),
    .quarters  (dec_q)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pend_q <= 4'd0;
    else          pend_q <= dec_q;
  end

  ssc_step_rom #(.RATIO_W(RATIO_W), .NOM(NOM_L), .HALF_CYC(HALF_CYC)) u_rom_pend (
    .quarters (pend_q),
    .step     (step_pend)
  );

  ssc_step_rom #(.RATIO_W(RATIO_W), .NOM(NOM_L), .HALF_CYC(HALF_CYC)) u_rom_cur (
    .quarters (cur_q),
    .step     (step_cur)
  );

  ssc_sweep_core #(.RATIO_W(RATIO_W), .HALF_CYC(HALF_CYC)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .pend_q    (pend_q),
    .step_pend (step_pend),
    .step_cur  (step_cur),
    .cur_q     (cur_q),
    .off_q     (off_q)
  );

  assign ratio     = NOM - off_q;
  assign spread_on = (cur_q != 4'd0);

  AST_RATIO_CEIL: assert property (@(posedge clk) disable iff (!rst_n_s)
    ratio <= NOM); // R6

  AST_OFF_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !spread_on |-> (ratio == NOM)); // R3

  AST_SMOOTH: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(spread_on) && spread_on |-> ((ratio == $past(ratio) - step_cur) ||
                                       (ratio == $past(ratio) + step_cur))); // R5
endmodule

// File: tb/sim_ssc_ratio_gen.sv
`timescale 1ns/1ps
module sim_ssc_ratio_gen;
  localparam int HALF = 422;
  localparam int PER  = 2 * HALF;
  localparam int NOM  = 3883615;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  sel_outer, sel_inner;
  logic [23:0] ratio;
  logic        spread_on;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ssc_ratio_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_outer (sel_outer),
    .sel_inner (sel_inner),
    .ratio     (ratio),
    .spread_on (spread_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl(input int c);
    return (c == 3) ? 0 : c;
  endfunction

  // R2 depth table in quarter percent, indexed by outer then inner level
  function automatic int depth_q(input int o, input int i);
    int t[3][3] = '{'{0, 2, 10}, '{1, 3, 4}, '{6, 8, 12}};
    return t[lvl(o)][lvl(i)];
  endfunction

  function automatic int step_of(input int q);
    return int'((longint'(NOM) * q) / (400 * HALF));
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // checks one full period; optionally changes selects at cycle sw_k
  task automatic sweep(input int q, input int sw_k, input int no, input int ni, input string tag);
    int st = step_of(q);
    int bad_a = 0, bad_e = 0, nbad = 0;
    for (int k = 0; k < PER; k++) begin
      int t = (k + 1 <= HALF) ? k + 1 : PER - (k + 1);
      int e = NOM - st * t;
      if (k == sw_k) begin
        sel_outer = 2'(no);
        sel_inner = 2'(ni);
      end
      if (ratio != 24'(e) || spread_on !== 1'b1) begin
        if (nbad == 0) begin
          bad_a = int'(ratio);
          bad_e = e;
        end
        nbad++;
      end
      if (k == HALF - 1) chk(ratio == 24'(NOM - st * HALF), "R6", int'(ratio), NOM - st * HALF);
      if (k < PER - 1) tick();
    end
    chk(nbad == 0, tag, bad_a, bad_e);
    chk(ratio == 24'(NOM), "R4", int'(ratio), NOM);
  endtask

  task automatic go_off;
    int n = 0;
    sel_outer = 2'b00;
    sel_inner = 2'b00;
    while (spread_on === 1'b1 && n < PER + 4) begin
      tick();
      n++;
    end
    chk(n <= PER + 2, "R7", n, PER + 2);
    chk(spread_on === 1'b0 && ratio == 24'(NOM), "R3", int'(ratio), NOM);
    repeat (5) tick();
    chk(spread_on === 1'b0 && ratio == 24'(NOM), "R3", int'(ratio), NOM);
  endtask

  task automatic from_off(input int o, input int i);
    int q = depth_q(o, i);
    sel_outer = 2'(o);
    sel_inner = 2'(i);
    tick();
    chk(spread_on === 1'b0, "R7", int'(spread_on), 0);
    tick();
    if (q == 0) begin
      int seen = 0;
      for (int k = 0; k < PER + 10; k++) begin
        if (spread_on !== 1'b0 || ratio != 24'(NOM)) seen++;
        tick();
      end
      chk(seen == 0, "R2", seen, 0);
    end else begin
      chk(spread_on === 1'b1, "R8", int'(spread_on), 1);
      sweep(q, -1, 0, 0, "R5");
      go_off();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sel_outer = 2'b10;
    sel_inner = 2'b10;
    repeat (3) tick();
    chk(ratio == 24'(NOM), "R1", int'(ratio), NOM);
    chk(spread_on === 1'b0, "R1", int'(spread_on), 0);
    sel_outer = 2'b00;
    sel_inner = 2'b00;
    rst_n = 1'b1;
    repeat (4) tick();
    chk(ratio == 24'(NOM) && spread_on === 1'b0, "R1", int'(ratio), NOM);

    // R2 full selection table
    for (int o = 0; o < 3; o++)
      for (int i = 0; i < 3; i++)
        from_off(o, i);

    // R2 reserved code reads as low
    from_off(3, 1);
    from_off(0, 3);
    from_off(3, 3);

    // R7 change in mid ramp: old step to the top, then the new one
    sel_outer = 2'b10;
    sel_inner = 2'b10;
    tick();
    tick();
    sweep(12, 100, 1, 0, "R7");
    tick();
    chk(spread_on === 1'b1, "R8", int'(spread_on), 1);
    sweep(1, -1, 0, 0, "R7");
    go_off();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule